// File: doc/BRIEF.md
# Load-Store Ordering Queue

This block sits between the rename/dispatch stage and the data cache of an out-of-order core. It decides when each memory micro-op may be sent to the cache. Micro-ops enter in program order through an allocate port and are each given a slot index in an 8-entry circular queue. A store is tracked as two halves. The address half arrives through the address writeback port, and the data half arrives through the data writeback port. A load receives only its address. Each cycle the queue grants at most one entry that is ready, and it always picks the oldest one.

Ordering between loads and stores follows one of two modes, chosen by a live mode input. In the safe mode, a load waits behind every older store whose address is still unknown. In the speculative mode, a load that was predicted not to alias at allocation time may go ahead of such stores. If one of those stores later resolves to the same address as a load that was already granted, the queue raises a one-cycle flush. The flush names the offending load, and that load and every younger entry are removed so that they can be dispatched again.

Top module: `lsq_order_queue`

## Requirements
- R1: After reset, alloc_ready is 1, alloc_idx is 0, and grant_valid and flush_valid are 0. Accepted allocations receive consecutive slot indices that wrap modulo 8. While 8 entries are held, alloc_ready is 0 and an allocate request is ignored.
- R2: A store is granted only after both its address and its data have been written. Stores are granted in program order with respect to one another.
- R3: A load whose address is known is not granted while an older, not yet granted store holds the same known address.
- R4: With disamb_en = 0, a load is not granted while any older, not yet granted store has an unknown address.
- R5: With disamb_en = 1, a load allocated with alloc_pred_alias = 0 may be granted past older stores whose addresses are unknown. A load allocated with alloc_pred_alias = 1 still waits for them, as in R4.
- R6: Once an older store's address resolves to a different address, that store no longer holds back a younger load, even while the store's data is still missing.
- R7: When an address write resolves a store's address to the address of a younger load that was already granted, flush_valid is 1 in that same cycle and flush_idx names the oldest such load. In that cycle alloc_ready is 0. That load and every younger entry are removed, later writes to them are ignored, and the next allocation receives index flush_idx.
- R8: At most one entry is granted per cycle, the oldest ready entry first, and each entry is granted once.
- R9: Granted entries leave the queue from the oldest end, which frees their slots for allocation.
- R10: grant_addr and grant_data carry the values written for the granted entry. grant_store is 1 for a store and 0 for a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disamb_en | input | 1 | 1 = speculative load hoisting, 0 = safe ordering |
| alloc_valid | input | 1 | Allocate a micro-op this cycle |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_pred_alias | input | 1 | Load predicted to alias an older store |
| alloc_ready | output | 1 | Allocation will be accepted |
| alloc_idx | output | 3 | Slot the next allocation receives |
| aw_valid | input | 1 | Address writeback |
| aw_idx | input | 3 | Slot receiving the address |
| aw_addr | input | 32 | Word-aligned address |
| dw_valid | input | 1 | Store data writeback |
| dw_idx | input | 3 | Slot receiving the data |
| dw_data | input | 32 | Store data |
| grant_valid | output | 1 | An entry is issued this cycle |
| grant_idx | output | 3 | Slot issued |
| grant_store | output | 1 | Issued entry is a store |
| grant_addr | output | 32 | Address of issued entry |
| grant_data | output | 32 | Data of issued store |
| flush_valid | output | 1 | Alias misprediction pulse |
| flush_idx | output | 3 | Oldest offending load slot |

## Verification
The bench runs the ordering rules with several store/load arrangements. Two stores whose halves arrive out of order tell in-order store issue apart from first-ready issue. A load behind an unresolved store is run in each mode, and with each prediction, to separate safe blocking from speculative hoisting. Resolving a store to a different address while its data is still missing shows that the hold is released early. Resolving a store to the same address as a hoisted load, with a second hoisted load behind it, checks that the flush names the oldest victim and trims the tail. A full queue of loads shows that a refused allocation does not move the tail, and that retirement frees the slot.

// File: rtl/lsq_pkg.sv
// Shared types for the load-store ordering queue.
package lsq_pkg;

    // Per-slot status flags.
    typedef struct packed {
        logic valid;       // slot holds a live micro-op
        logic is_store;    // 1 = store, 0 = load
        logic pred_alias;  // load predicted to alias an older store
        logic addr_ok;     // address has been written
        logic data_ok;     // store data has been written
        logic issued;      // entry has been granted
    } lsq_flags_t;

endpackage

// File: rtl/lsq_age_pick.sv
// Oldest-first picker over a circular queue.
// Scans from the head slot upward and returns the first requesting slot.
// Assumes DEPTH is a power of two so that index arithmetic wraps naturally.
module lsq_age_pick #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] req,
    input  logic [IDX_W-1:0] head,
    output logic             found,
    output logic [IDX_W-1:0] pick
);

    logic [IDX_W-1:0] slot_w;

    // Walk from youngest to oldest position so the oldest request is kept last.
    always_comb begin
        found  = 1'b0;
        pick   = head;
        slot_w = head;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            slot_w = head + IDX_W'(k);
            if (req[slot_w]) begin
                found = 1'b1;
                pick  = slot_w;
            end
        end
    end

endmodule

// File: rtl/lsq_ready_eval.sv
// Readiness evaluation for every slot of the ordering queue.
// A store is ready once its address and data are known and no older store
// is still pending. A load is ready once its address is known and no older
// pending store either matches it or, depending on mode and prediction,
// has an unknown address. Age is the distance from the head slot.
module lsq_ready_eval
    import lsq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  lsq_flags_t [DEPTH-1:0]             flg,
    input  logic       [DEPTH-1:0][ADDR_W-1:0] addr,
    input  logic       [IDX_W-1:0]             head,
    input  logic                               disamb_en,
    output logic       [DEPTH-1:0]             rdy
);

    // Compare every slot against every older pending store.
    always_comb begin
        rdy = '0;
        for (int i = 0; i < DEPTH; i++) begin : g_row
            logic [IDX_W-1:0] rel_i;
            logic             blk;
            logic             may_hoist;
            rel_i     = IDX_W'(i) - head;
            blk       = 1'b0;
            may_hoist = disamb_en && !flg[i].pred_alias;
            for (int j = 0; j < DEPTH; j++) begin : g_col
                logic [IDX_W-1:0] rel_j;
                rel_j = IDX_W'(j) - head;
                if (flg[j].valid && flg[j].is_store && !flg[j].issued && (rel_j < rel_i)) begin
                    if (flg[i].is_store) begin
                        blk = 1'b1;
                    end else if (!flg[j].addr_ok) begin
                        if (!may_hoist) blk = 1'b1;
                    end else if (addr[j] == addr[i]) begin
                        blk = 1'b1;
                    end
                end
            end
            rdy[i] = flg[i].valid && !flg[i].issued && flg[i].addr_ok &&
                     (!flg[i].is_store || flg[i].data_ok) && !blk;
        end
    end

endmodule

// File: rtl/lsq_alias_check.sv
// Late alias detection.
// When a store's address arrives for the first time, every younger load that
// has been granted (or is being granted this cycle) with the same address is
// a misprediction victim. The oldest victim is reported.
module lsq_alias_check
    import lsq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  lsq_flags_t [DEPTH-1:0]             flg,
    input  logic       [DEPTH-1:0][ADDR_W-1:0] addr,
    input  logic       [IDX_W-1:0]             head,
    input  logic                               wb_valid,
    input  logic       [IDX_W-1:0]             wb_idx,
    input  logic       [ADDR_W-1:0]            wb_addr,
    input  logic                               grant_valid,
    input  logic       [IDX_W-1:0]             grant_idx,
    output logic                               flush_valid,
    output logic       [IDX_W-1:0]             flush_idx
);

    logic             trig;
    logic [IDX_W-1:0] rel_wb;
    logic [DEPTH-1:0] hit;

    // Detect a store address arriving for a live store that had none.
    always_comb begin
        trig   = wb_valid && flg[wb_idx].valid && flg[wb_idx].is_store && !flg[wb_idx].addr_ok;
        rel_wb = wb_idx - head;
    end

    // Mark younger granted loads whose address matches the new store address.
    always_comb begin
        hit = '0;
        for (int i = 0; i < DEPTH; i++) begin : g_hit
            logic [IDX_W-1:0] rel_i;
            logic             gone;
            rel_i  = IDX_W'(i) - head;
            gone   = flg[i].issued || (grant_valid && (grant_idx == IDX_W'(i)));
            hit[i] = trig && flg[i].valid && !flg[i].is_store && gone &&
                     flg[i].addr_ok && (addr[i] == wb_addr) && (rel_i > rel_wb);
        end
    end

    lsq_age_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_victim (
        .req   (hit),
        .head  (head),
        .found (flush_valid),
        .pick  (flush_idx)
    );

endmodule

// File: rtl/lsq_order_queue.sv
// Load-store ordering queue (top).
// Holds up to DEPTH memory micro-ops in allocation order, collects their
// addresses and store data, grants the oldest ready entry each cycle and
// reports alias mispredictions of hoisted loads as a flush of the tail.
// Assumes DEPTH is a power of two and addresses are full word addresses.
module lsq_order_queue
    import lsq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disamb_en,
    input  logic              alloc_valid,
    input  logic              alloc_store,
    input  logic              alloc_pred_alias,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              aw_valid,
    input  logic [IDX_W-1:0]  aw_idx,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic              dw_valid,
    input  logic [IDX_W-1:0]  dw_idx,
    input  logic [DATA_W-1:0] dw_data,
    output logic              grant_valid,
    output logic [IDX_W-1:0]  grant_idx,
    output logic              grant_store,
    output logic [ADDR_W-1:0] grant_addr,
    output logic [DATA_W-1:0] grant_data,
    output logic              flush_valid,
    output logic [IDX_W-1:0]  flush_idx
);

    localparam int CNT_W = IDX_W + 1;

    lsq_flags_t [DEPTH-1:0]             flg_q;
    logic       [DEPTH-1:0][ADDR_W-1:0] addr_q;
    logic       [DEPTH-1:0][DATA_W-1:0] data_q;
    logic       [CNT_W-1:0]             head_q;
    logic       [CNT_W-1:0]             tail_q;
    logic       [CNT_W-1:0]             count_w;
    logic       [IDX_W-1:0]             head_idx;
    logic       [IDX_W-1:0]             flush_rel;
    logic       [DEPTH-1:0]             rdy_w;
    logic       [DEPTH-1:0]             kill_w;
    logic                               retire_w;
    logic                               alloc_fire;

    // Occupancy, retirement and allocation acceptance.
    always_comb begin
        head_idx    = head_q[IDX_W-1:0];
        count_w     = tail_q - head_q;
        retire_w    = flg_q[head_idx].valid && flg_q[head_idx].issued;
        alloc_ready = (count_w < CNT_W'(DEPTH)) && !flush_valid;
        alloc_idx   = tail_q[IDX_W-1:0];
        alloc_fire  = alloc_valid && alloc_ready;
        flush_rel   = flush_idx - head_idx;
    end

    // Slots removed by a flush: from the victim up to the tail.
    always_comb begin
        kill_w = '0;
        for (int i = 0; i < DEPTH; i++) begin : g_kill
            logic [IDX_W-1:0] rel_i;
            rel_i     = IDX_W'(i) - head_idx;
            kill_w[i] = flush_valid && (rel_i >= flush_rel) && ({1'b0, rel_i} < count_w);
        end
    end

    lsq_ready_eval #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ready (
        .flg       (flg_q),
        .addr      (addr_q),
        .head      (head_idx),
        .disamb_en (disamb_en),
        .rdy       (rdy_w)
    );

    lsq_age_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_grant (
        .req   (rdy_w),
        .head  (head_idx),
        .found (grant_valid),
        .pick  (grant_idx)
    );

    lsq_alias_check #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_alias (
        .flg         (flg_q),
        .addr        (addr_q),
        .head        (head_idx),
        .wb_valid    (aw_valid),
        .wb_idx      (aw_idx),
        .wb_addr     (aw_addr),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .flush_valid (flush_valid),
        .flush_idx   (flush_idx)
    );

    // Drive the granted entry's payload.
    always_comb begin
        grant_store = flg_q[grant_idx].is_store;
        grant_addr  = addr_q[grant_idx];
        grant_data  = data_q[grant_idx];
    end

    // Slot status and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            flg_q  <= '0;
        end else begin
            if (aw_valid && flg_q[aw_idx].valid) begin
                flg_q[aw_idx].addr_ok <= 1'b1;
            end
            if (dw_valid && flg_q[dw_idx].valid && flg_q[dw_idx].is_store) begin
                flg_q[dw_idx].data_ok <= 1'b1;
            end
            if (grant_valid) begin
                flg_q[grant_idx].issued <= 1'b1;
            end
            if (retire_w) begin
                flg_q[head_idx].valid <= 1'b0;
                head_q                <= head_q + 1'b1;
            end
            if (flush_valid) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (kill_w[i]) flg_q[i].valid <= 1'b0;
                end
                tail_q <= head_q + CNT_W'(flush_rel);
            end else if (alloc_fire) begin
                flg_q[alloc_idx] <= '{valid: 1'b1, is_store: alloc_store,
                                      pred_alias: alloc_pred_alias, addr_ok: 1'b0,
                                      data_ok: 1'b0, issued: 1'b0};
                tail_q           <= tail_q + 1'b1;
            end
        end
    end

    // Address and data storage; contents are qualified by the status flags.
    always_ff @(posedge clk) begin
        if (aw_valid) addr_q[aw_idx] <= aw_addr;
        if (dw_valid) data_q[dw_idx] <= dw_data;
    end

endmodule

// File: rtl/lsq_order_queue_chk.sv
// Property checker for the load-store ordering queue, bound to the top.
// Observes the slot flags, pointers and the grant and flush outputs.
module lsq_order_queue_chk
    import lsq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   disamb_en,
    input lsq_flags_t [DEPTH-1:0] flg,
    input logic [IDX_W:0]         head,
    input logic [IDX_W:0]         count,
    input logic                   grant_valid,
    input logic [IDX_W-1:0]       grant_idx,
    input logic                   grant_store,
    input logic                   flush_valid,
    input logic [IDX_W-1:0]       flush_idx
);

    logic [IDX_W-1:0] fidx_d;
    logic [IDX_W-1:0] flush_rel;
    logic             older_unknown;

    // Remember the flushed slot for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fidx_d <= '0;
        else        fidx_d <= flush_idx;
    end

    // Position of the flush victim and unresolved older stores of the grant.
    always_comb begin
        flush_rel     = flush_idx - head[IDX_W-1:0];
        older_unknown = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (flg[j].valid && flg[j].is_store && !flg[j].issued && !flg[j].addr_ok &&
                ((IDX_W'(j) - head[IDX_W-1:0]) < (grant_idx - head[IDX_W-1:0])))
                older_unknown = 1'b1;
        end
    end

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (IDX_W+1)'(DEPTH));

    // R2
    store_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_store) |-> (flg[grant_idx].addr_ok && flg[grant_idx].data_ok));

    // R8
    grant_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (flg[grant_idx].valid && !flg[grant_idx].issued));

    // R4
    safe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_store && !disamb_en) |-> !older_unknown);

    // R7
    flush_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> ({1'b0, flush_rel} < count));

    // R7
    flush_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !flg[fidx_d].valid);

endmodule

bind lsq_order_queue lsq_order_queue_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disamb_en   (disamb_en),
    .flg         (flg_q),
    .head        (head_q),
    .count       (count_w),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .grant_store (grant_store),
    .flush_valid (flush_valid),
    .flush_idx   (flush_idx)
);

// File: tb/tb_lsq_order_queue.sv
`timescale 1ns/1ps
module tb_lsq_order_queue;

    localparam int DEPTH = 8;
    localparam int IW    = 3;
    localparam int AW    = 32;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          disamb_en;
    logic          alloc_valid, alloc_store, alloc_pred_alias;
    logic          alloc_ready;
    logic [IW-1:0] alloc_idx;
    logic          aw_valid;
    logic [IW-1:0] aw_idx;
    logic [AW-1:0] aw_addr;
    logic          dw_valid;
    logic [IW-1:0] dw_idx;
    logic [DW-1:0] dw_data;
    logic          grant_valid, grant_store;
    logic [IW-1:0] grant_idx;
    logic [AW-1:0] grant_addr;
    logic [DW-1:0] grant_data;
    logic          flush_valid;
    logic [IW-1:0] flush_idx;

    always #2.5 clk = ~clk;

    lsq_order_queue dut (
        .clk(clk), .rst_n(rst_n), .disamb_en(disamb_en),
        .alloc_valid(alloc_valid), .alloc_store(alloc_store),
        .alloc_pred_alias(alloc_pred_alias), .alloc_ready(alloc_ready),
        .alloc_idx(alloc_idx), .aw_valid(aw_valid), .aw_idx(aw_idx),
        .aw_addr(aw_addr), .dw_valid(dw_valid), .dw_idx(dw_idx),
        .dw_data(dw_data), .grant_valid(grant_valid), .grant_idx(grant_idx),
        .grant_store(grant_store), .grant_addr(grant_addr),
        .grant_data(grant_data), .flush_valid(flush_valid), .flush_idx(flush_idx)
    );

    typedef struct {
        int     idx;
        bit     st;
        longint addr;
        longint data;
        string  req;
    } exp_t;

    exp_t sb[$];
    int   total = 0;
    int   bad   = 0;
    int   nxt   = 0;
    bit   done  = 0;

    task automatic check_eq(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) tick();
    endtask

    task automatic expect_grant(int idx, bit st, longint a, longint d, string req);
        exp_t e;
        e.idx = idx; e.st = st; e.addr = a; e.data = d; e.req = req;
        sb.push_back(e);
    endtask

    task automatic alloc(bit st, bit pred, output int idx);
        alloc_valid = 1'b1; alloc_store = st; alloc_pred_alias = pred;
        check_eq("R1", "alloc_idx", alloc_idx, nxt);
        idx = nxt;
        tick();
        alloc_valid = 1'b0;
        nxt = (nxt + 1) % DEPTH;
    endtask

    task automatic wr_addr(int idx, longint a);
        aw_valid = 1'b1; aw_idx = IW'(idx); aw_addr = AW'(a);
        tick();
        aw_valid = 1'b0;
    endtask

    task automatic wr_data(int idx, longint d);
        dw_valid = 1'b1; dw_idx = IW'(idx); dw_data = DW'(d);
        tick();
        dw_valid = 1'b0;
    endtask

    // Address write with a check of the flush output in the driven cycle.
    task automatic wr_addr_chk(int idx, longint a, bit ef, int eidx, string req);
        aw_valid = 1'b1; aw_idx = IW'(idx); aw_addr = AW'(a);
        @(negedge clk);
        check_eq(req, "flush_valid", flush_valid, ef);
        if (ef) begin
            check_eq(req, "flush_idx", flush_idx, eidx);
            check_eq(req, "alloc_ready in flush", alloc_ready, 0);
        end
        @(posedge clk);
        #1;
        aw_valid = 1'b0;
    endtask

    task automatic no_grant(string req);
        @(negedge clk);
        check_eq(req, "grant_valid while held", grant_valid, 0);
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare every grant with the next scoreboard item.
    always @(negedge clk) begin
        if (rst_n && grant_valid && !done) begin
            if (sb.size() == 0) begin
                check_eq("R8", "unexpected grant idx", grant_idx, 99);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check_eq(e.req, "grant_idx", grant_idx, e.idx);
                check_eq(e.req, "grant_store", grant_store, e.st);
                check_eq(e.req, "grant_addr", grant_addr, e.addr);
                if (e.st) check_eq(e.req, "grant_data", grant_data, e.data);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s0, s1, l0, l1, la, lb, s2;
        rst_n = 1'b0; disamb_en = 1'b0;
        alloc_valid = 0; alloc_store = 0; alloc_pred_alias = 0;
        aw_valid = 0; aw_idx = '0; aw_addr = '0;
        dw_valid = 0; dw_idx = '0; dw_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1", "reset alloc_ready", alloc_ready, 1);
        check_eq("R1", "reset alloc_idx", alloc_idx, 0);
        check_eq("R1", "reset grant_valid", grant_valid, 0);
        check_eq("R1", "reset flush_valid", flush_valid, 0);
        tick();

        // R2 / R10: younger store complete first, still waits for the older one
        alloc(1, 0, s0);
        alloc(1, 0, s1);
        wr_addr(s1, 'h10);
        wr_data(s1, 'hB1);
        no_grant("R2");
        wr_addr(s0, 'h20);
        expect_grant(s0, 1, 'h20, 'hA0, "R2/R10");
        expect_grant(s1, 1, 'h10, 'hB1, "R2/R10");
        wr_data(s0, 'hA0);
        idle(3);

        // R4 safe mode: load held by unknown store address; R6 release
        disamb_en = 1'b0;
        alloc(1, 0, s0);
        alloc(0, 0, l0);
        wr_addr(l0, 'h40);
        no_grant("R4");
        no_grant("R4");
        expect_grant(l0, 0, 'h40, 0, "R6");
        wr_addr(s0, 'h80);
        idle(2);
        expect_grant(s0, 1, 'h80, 'hC2, "R2");
        wr_data(s0, 'hC2);
        idle(3);

        // R3: load held by older store with the same known address
        alloc(1, 0, s0);
        alloc(0, 0, l0);
        wr_addr(s0, 'h100);
        wr_addr(l0, 'h100);
        no_grant("R3");
        no_grant("R3");
        expect_grant(s0, 1, 'h100, 'hD3, "R3");
        expect_grant(l0, 0, 'h100, 0, "R3");
        wr_data(s0, 'hD3);
        idle(3);

        // R5 speculative mode: predicted-alias load waits, other hoists; R8 oldest first
        disamb_en = 1'b1;
        alloc(1, 0, s0);
        alloc(0, 1, la);
        alloc(0, 0, lb);
        wr_addr(la, 'h200);
        no_grant("R5");
        expect_grant(lb, 0, 'h300, 0, "R5");
        wr_addr(lb, 'h300);
        wr_data(s0, 'hE4);
        no_grant("R5");
        expect_grant(s0, 1, 'h400, 'hE4, "R8");
        expect_grant(la, 0, 'h200, 0, "R8");
        wr_addr_chk(s0, 'h400, 0, 0, "R7");
        idle(3);

        // R7: late alias resolves against two hoisted loads
        alloc(1, 0, s0);
        alloc(0, 0, l0);
        alloc(1, 0, s2);
        alloc(0, 0, l1);
        expect_grant(l0, 0, 'h500, 0, "R5");
        wr_addr(l0, 'h500);
        expect_grant(l1, 0, 'h600, 0, "R5");
        wr_addr(l1, 'h600);
        idle(2);
        wr_addr_chk(s0, 'h500, 1, l0, "R7");
        nxt = l0;
        @(negedge clk);
        check_eq("R7", "flush after pulse", flush_valid, 0);
        check_eq("R7", "alloc_idx after flush", alloc_idx, l0);
        tick();
        wr_addr(s2, 'h900);
        wr_data(s2, 'h99);
        expect_grant(s0, 1, 'h500, 'hF5, "R7");
        wr_data(s0, 'hF5);
        idle(2);
        alloc(0, 0, l0);
        expect_grant(l0, 0, 'h700, 0, "R7");
        wr_addr(l0, 'h700);
        idle(4);

        // R1 / R9: fill the queue, refused allocation, slot freed by retirement
        disamb_en = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            int tmp;
            alloc(0, 0, tmp);
        end
        check_eq("R1", "alloc_ready when full", alloc_ready, 0);
        alloc_valid = 1'b1; alloc_store = 1'b1;
        tick();
        alloc_valid = 1'b0;
        check_eq("R1", "alloc_ready after refused", alloc_ready, 0);
        expect_grant(nxt, 0, 'h1000, 0, "R9");
        wr_addr(nxt, 'h1000);
        idle(3);
        check_eq("R9", "alloc_ready after retire", alloc_ready, 1);
        check_eq("R1", "tail unmoved by refused alloc", alloc_idx, nxt);
        for (int k = 1; k < DEPTH; k++) begin
            int ix;
            ix = (nxt + k) % DEPTH;
            expect_grant(ix, 0, 'h1000 + k * 16, 0, "R8");
            wr_addr(ix, 'h1000 + k * 16);
        end
        alloc(1, 0, s0);
        wr_addr(s0, 'h2000);
        expect_grant(s0, 1, 'h2000, 'h77, "R10");
        wr_data(s0, 'h77);
        idle(6);

        check_eq("R8", "pending expected grants", sb.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule